// File: doc/BRIEF.md
# Interval Timer with Auto-Reload

This block is a small register-mapped interval timer for an embedded processor subsystem. Software programs a start value, then sets control bits. When counting is enabled, a down counter steps toward zero once per clock. The cycle in which an enabled counter sits at zero is a timeout. A timeout raises a sticky flag that software reads and clears.

A control bit picks the mode after a timeout. In periodic mode the counter restarts from the stored start value, so a start value of L gives a timeout every L+1 clocks. At 200 MHz, a start value of 199,999,999 therefore gives one-second ticks. In single-shot mode the counter rests at zero and stays quiet until software writes a new start value. A separate control bit lets the sticky flag drive an interrupt line.

The register port is a simple synchronous one. Writes take effect at the clock edge where the write strobe is high. Read data is registered: it shows the register addressed at the previous edge, as that register stood just before that edge.

Top module: `ival_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is 0.
- R2: Byte offsets: start value 0x0 (read/write), live counter 0x4 (read-only), control 0x8 (bits 2:0 read back), status 0xC (bit 0 is the flag, the other bits read 0). `bus_rdata` is registered and shows the addressed register as it stood before the edge that captured it. A write to offset 0x0 loads both the start value and the counter at once.
- R3: Control bit 0 enables counting. While enabled and nonzero, the counter drops by exactly 1 per clock. While disabled, it holds its value.
- R4: A cycle in which the counter is enabled and equal to zero is a timeout, and it sets the flag. After enabling with start value L, the flag first reads 1 after L+1 clocks.
- R5: When control bit 1 is set, a timeout reloads the counter from the start value, so timeouts repeat every L+1 clocks.
- R6: When control bit 1 is clear, the counter stays at zero after a timeout and produces no further timeout until offset 0x0 is written again.
- R7: The flag is sticky. A write to offset 0xC with data bit 0 = 1 clears it. A write with bit 0 = 0 leaves it unchanged. If a timeout falls in the same cycle as a clear, the flag stays set.
- R8: `irq` is high exactly when the flag is set and control bit 2 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
A counter that is off by one shows up as a timeout that arrives one clock early or late. A wrong reload value stretches or shortens the second and later periods. Both faults appear on `irq` within one period of the event. A flag that is stuck, fails to stay set, or loses a timeout that lands on a clear shows up on the next status read, and on `irq` in the cycle right after the edge. Single-shot faults show up as a second `irq` while the counter rests at zero.

// File: rtl/ival_pkg.sv
package ival_pkg;
  typedef struct packed {
    logic irq_en;
    logic auto_rl;
    logic run;
  } ival_ctrl_t;

  localparam logic [3:0] OFF_START = 4'h0;
  localparam logic [3:0] OFF_COUNT = 4'h4;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam logic [3:0] OFF_STAT  = 4'hC;
endpackage

// File: rtl/ival_regs.sv
module ival_regs
  import ival_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  start_q,
  output ival_ctrl_t        ctrl_q,
  output logic              start_wr,
  output logic              clr_wr,
  output logic [CNT_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic             ctrl_wr;
  logic [CNT_W-1:0] rd_mux;

  assign start_wr = bus_wr && (bus_addr == A_START);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign clr_wr   = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_START)      rd_mux = start_q;
    else if (bus_addr == A_COUNT) rd_mux = cnt_i;
    else if (bus_addr == A_CTRL)  rd_mux = CNT_W'(ctrl_q);
    else if (bus_addr == A_STAT)  rd_mux = {{(CNT_W-1){1'b0}}, flag_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (start_wr) start_q <= bus_wdata;
      if (ctrl_wr)  ctrl_q  <= ival_ctrl_t'(bus_wdata[2:0]);
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ival_count.sv
module ival_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             auto_rl,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed_q;

  assign tick = run && (cnt_q == '0) && (auto_rl || armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (start_wr) begin
      cnt_q   <= wdata;
      armed_q <= 1'b1;
    end else if (tick) begin
      armed_q <= 1'b0;
      if (auto_rl) cnt_q <= start_q;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/ival_flag.sv
module ival_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr_wr,
  input  logic irq_en,
  output logic flag_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (tick)   flag_q <= 1'b1;
    else if (clr_wr) flag_q <= 1'b0;
  end

  assign irq = flag_q & irq_en;
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  ival_ctrl_t       ctrl_q;
  logic             start_wr;
  logic             clr_wr;
  logic             tick;
  logic             flag_q;

  ival_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .cnt_i(cnt_q), .flag_i(flag_q),
    .start_q(start_q), .ctrl_q(ctrl_q), .start_wr(start_wr),
    .clr_wr(clr_wr), .bus_rdata(bus_rdata)
  );

  ival_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .auto_rl(ctrl_q.auto_rl),
    .start_wr(start_wr), .wdata(bus_wdata), .start_q(start_q),
    .cnt_q(cnt_q), .tick(tick)
  );

  ival_flag u_flag (
    .clk(clk), .rst(rst), .tick(tick), .clr_wr(clr_wr),
    .irq_en(ctrl_q.irq_en), .flag_q(flag_q), .irq(irq)
  );
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wbit0,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  start_q,
  input logic [2:0]        ctrl_bits,
  input logic              tick,
  input logic              flag_q,
  input logic              irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic run, auto_rl, irq_en, ld, clr;
  assign run     = ctrl_bits[0];
  assign auto_rl = ctrl_bits[1];
  assign irq_en  = ctrl_bits[2];
  assign ld      = bus_wr && (bus_addr == ADDR_W'(4'h0));
  assign clr     = bus_wr && (bus_addr == ADDR_W'(4'hC)) && wbit0;

  // R3
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q != '0 && !ld) |=> cnt_q == $past(cnt_q) - ONE);
  // R3
  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld) |=> $stable(cnt_q));
  // R4
  a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
    tick |=> flag_q);
  // R5
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && auto_rl && !ld) |=> cnt_q == $past(start_q));
  // R6
  a_r6_rest_zero: assert property (@(posedge clk) disable iff (rst)
    (!auto_rl && cnt_q == '0 && !ld) |=> cnt_q == '0);
  // R7
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R7
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick) |=> !flag_q);
  // R8
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_en && flag_q));
  // R8
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (irq_en && flag_q) |-> irq);
endmodule

bind ival_timer ival_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wbit0(bus_wdata[0]), .cnt_q(cnt_q), .start_q(start_q),
  .ctrl_bits(ctrl_q), .tick(tick), .flag_q(flag_q), .irq(irq)
);

// File: tb/sim_ival_timer.sv
`timescale 1ns/1ps
module sim_ival_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ival_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h1);
  endtask

  initial begin
    logic [31:0] v, v2;
    idle(2);
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    rd(4'h0, v); chk("R1 start", v, 0);
    rd(4'h4, v); chk("R1 count", v, 0);
    rd(4'h8, v); chk("R1 ctrl", v, 0);
    rd(4'hC, v); chk("R1 status", v, 0);

    // R2: start write loads counter too; control readback
    wr(4'h0, 32'hA5A5_1234);
    rd(4'h0, v); chk("R2 start readback", v, 32'hA5A5_1234);
    rd(4'h4, v); chk("R2 counter loaded", v, 32'hA5A5_1234);
    wr(4'h8, 32'hFFFF_FFF8);
    rd(4'h8, v); chk("R2 ctrl bits only", v, 32'h0);
    rd(4'h4, v); chk("R3 held while off", v, 32'hA5A5_1234);

    // R4/R6: single-shot sweep of start values
    for (int L = 0; L <= 6; L++) begin
      quiesce();
      wr(4'h0, L);
      wr(4'h8, 32'h5);
      idle(L);
      chk($sformatf("R4 no early timeout L=%0d", L), {31'b0, irq}, 0);
      idle(1);
      chk($sformatf("R4 timeout L=%0d", L), {31'b0, irq}, 1);
      wr(4'hC, 32'h1);
      idle(5);
      chk($sformatf("R6 no refire L=%0d", L), {31'b0, irq}, 0);
      rd(4'h4, v); chk($sformatf("R6 rests at zero L=%0d", L), v, 0);
    end
    // R6: rewrite of start re-arms single-shot
    wr(4'h0, 2);
    idle(2);
    chk("R6 rearm early", {31'b0, irq}, 0);
    idle(1);
    chk("R6 rearm fires", {31'b0, irq}, 1);

    // R5: periodic sweep
    for (int L = 1; L <= 6; L++) begin
      quiesce();
      wr(4'h0, L);
      wr(4'h8, 32'h7);
      idle(L + 1);
      chk($sformatf("R5 first timeout L=%0d", L), {31'b0, irq}, 1);
      wr(4'hC, 32'h1);
      idle(L - 1);
      chk($sformatf("R5 second not early L=%0d", L), {31'b0, irq}, 0);
      idle(1);
      chk($sformatf("R5 second timeout L=%0d", L), {31'b0, irq}, 1);
    end

    // R3: live readout decrements one per clock, pauses when disabled
    quiesce();
    wr(4'h0, 100);
    wr(4'h8, 32'h1);
    rd(4'h4, v); chk("R3 count 100", v, 100);
    rd(4'h4, v); chk("R3 count 99", v, 99);
    rd(4'h4, v); chk("R3 count 98", v, 98);
    wr(4'h8, 32'h0);
    rd(4'h4, v);
    idle(4);
    rd(4'h4, v2); chk("R3 paused", v2, v);

    // R8 and R7: flag without interrupt enable, set wins over clear
    quiesce();
    wr(4'h0, 0);
    wr(4'h8, 32'h3);
    idle(3);
    chk("R8 masked irq", {31'b0, irq}, 0);
    rd(4'hC, v); chk("R7 flag set", v, 1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R7 set wins over clear", v, 1);
    wr(4'h8, 32'h7);
    chk("R8 irq on enable", {31'b0, irq}, 1);
    wr(4'h8, 32'h4);
    wr(4'hC, 32'h1);
    chk("R8 irq after clear", {31'b0, irq}, 0);

    // R7: write of 0 does not clear
    quiesce();
    wr(4'h0, 3);
    wr(4'h8, 32'h1);
    idle(5);
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0);
    rd(4'hC, v); chk("R7 write zero keeps flag", v, 1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R7 write one clears", v, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule